// File: doc/BRIEF.md
# Reset Cause and Peripheral Reset Lock Registers

This block is a small 32-bit register file that sits inside a reset manager. It keeps a record of why the device last came out of reset. Each reason has its own sticky flag, and a flag stays set until software clears it by writing a one to it. A new hardware event adds its flag to whatever flags are already set. A register never holds only the latest reason.

The block also gives software a reset control for each of two peripherals. Each control is an active-low bit. Writing 0 to it holds that peripheral in reset. Each control has its own lock bit. The lock starts out open, and software closes it by writing a one. Once closed, the lock stays closed until the next system reset, and the matching control is frozen for that whole time.

Access is through a plain synchronous register port with a byte address, a write strobe, write data and combinational read data.

Top module: `rcl_regfile`

## Requirements
- R1: After reset, the cause register reads 0x1, both lock bits read 1, both reset control bits read 1, and both peripheral reset outputs are high once the system reset is released.
- R2: Bit k of `cause_evt_i` sets bit k of the cause field. The bits mean: bit 0 power-on, bit 1 low-power exit, bit 2 watchdog, bit 3 security escalation, bit 4 request from a non-debug module.
- R3: Cause bits accumulate. An event ORs its bit into the stored value, and several bits may be set at the same time.
- R4: Writing the cause register clears each cause bit whose write-data bit is 1. A bit whose write-data bit is 0 keeps its value.
- R5: If a cause event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R6: Each lock bit resets to 1. Writing 1 to it in bit 0 clears it, and writing 0 leaves it unchanged. Once it reads 0, no write can set it back to 1.
- R7: A reset control bit takes bit 0 of the write data only while its lock bit is 1. Writes made while the lock bit is 0 are ignored.
- R8: Each `periph_rst_no[i]` equals `rst_ni` AND reset control bit i. It is low while the system reset is held, and low while the control bit is 0.
- R9: The register map uses byte addresses. 0x00 is the cause register, 0x04 is lock 0, 0x08 is lock 1, 0x0C is control 0 and 0x10 is control 1. Any other address reads 0, and writes to it change nothing.
- R10: Bits above the cause field, and bits above bit 0 in the lock and control registers, always read 0. Writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low system reset, asynchronous assert |
| reg_addr_i | input | 8 | Byte address of the access |
| reg_we_i | input | 1 | Write strobe, acts on the rising clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| cause_evt_i | input | 5 | Single-cycle hardware reset-cause events, one per cause bit |
| periph_rst_no | output | 2 | Active-low reset for each peripheral |

## Verification
The bench first runs directed sequences. Single events separate the cause bit positions from one another. Back-to-back events of different kinds show that bits accumulate rather than overwrite. A clear that collides with an event on the same bit shows that the event wins, while the same write still clears the other bits. Lock tests write zeros to show they are ignored, write a one to close the lock, then try to reopen it and to change the control. These tests tell a frozen control apart from one that is merely unchanged. Seeded random writes follow, spread over mapped addresses, unmapped addresses and upper data bits, with random event pulses mixed in. After every write the whole map is read back and compared with a bench model, which exposes any mis-decoded address or leaked upper bit.

// File: rtl/rcl_pkg.sv
package rcl_pkg;

  localparam int CAUSE_W = 5;

  typedef enum int unsigned {
    CAUSE_POWER_ON   = 0,
    CAUSE_LP_EXIT    = 1,
    CAUSE_WATCHDOG   = 2,
    CAUSE_ESCALATE   = 3,
    CAUSE_NDM_REQ    = 4
  } cause_idx_e;

  // Sticky merge: clear where software asks, then let events win.
  function automatic logic [CAUSE_W-1:0] cause_next(
    input logic [CAUSE_W-1:0] cur,
    input logic [CAUSE_W-1:0] clr,
    input logic [CAUSE_W-1:0] evt
  );
    return (cur & ~clr) | evt;
  endfunction

  // Byte address of lock register for peripheral idx.
  function automatic int unsigned lock_addr(input int unsigned idx);
    return 4 + 4 * idx;
  endfunction

  // Byte address of reset control register for peripheral idx.
  function automatic int unsigned ctrl_addr(input int unsigned idx, input int unsigned nper);
    return 4 + 4 * nper + 4 * idx;
  endfunction

endpackage

// File: rtl/rcl_cause_reg.sv
module rcl_cause_reg
  import rcl_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] RESET_VAL = CAUSE_W'(1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_en_i,
  input  logic [CAUSE_W-1:0] clr_bits_i,
  input  logic [CAUSE_W-1:0] evt_i,
  output logic [CAUSE_W-1:0] cause_o
);

  logic [CAUSE_W-1:0] clr_mask;
  logic [CAUSE_W-1:0] cause_q;

  assign clr_mask = clr_en_i ? clr_bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= RESET_VAL;
    end else begin
      cause_q <= cause_next(cause_q, clr_mask, evt_i);
    end
  end

  assign cause_o = cause_q;

  AST_CAUSE_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)))
    else $error("event bit not recorded"); // R3

  AST_CAUSE_NO_CLR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mask == '0) |=> ((cause_q & $past(cause_q)) == $past(cause_q)))
    else $error("cause bit lost without clear"); // R4

  AST_CAUSE_EVT_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_mask & evt_i) != '0) |=> ((cause_q & $past(clr_mask & evt_i)) != '0))
    else $error("clear beat event"); // R5

endmodule

// File: rtl/rcl_lock_ctrl.sv
module rcl_lock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_wr_i,
  input  logic ctrl_wr_i,
  input  logic wbit_i,
  output logic lock_open_o,
  output logic ctrl_o
);

  logic lock_q;
  logic ctrl_q;
  logic lock_close_evt;
  logic ctrl_take_evt;

  assign lock_close_evt = lock_wr_i & wbit_i;
  assign ctrl_take_evt  = ctrl_wr_i & lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
    end else if (lock_close_evt) begin
      lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 1'b1;
    end else if (ctrl_take_evt) begin
      ctrl_q <= wbit_i;
    end
  end

  assign lock_open_o = lock_q;
  assign ctrl_o      = ctrl_q;

  AST_LOCK_ONE_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !lock_q)
    else $error("lock reopened"); // R6

  AST_CTRL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> $stable(ctrl_q))
    else $error("control changed while locked"); // R7

endmodule

// File: rtl/rcl_read_mux.sv
module rcl_read_mux
  import rcl_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int N_PERIPH = 2
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CAUSE_W-1:0]  cause_i,
  input  logic [N_PERIPH-1:0] lock_i,
  input  logic [N_PERIPH-1:0] ctrl_i,
  output logic [DATA_W-1:0]   rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[CAUSE_W-1:0] = cause_i;
    end
    for (int i = 0; i < N_PERIPH; i++) begin
      if (addr_i == ADDR_W'(lock_addr(i))) begin
        rdata_o[0] = lock_i[i];
      end
      if (addr_i == ADDR_W'(ctrl_addr(i, N_PERIPH))) begin
        rdata_o[0] = ctrl_i[i];
      end
    end
  end

  always_comb begin
    AST_RDATA_UPPER_ZERO: assert (rdata_o[DATA_W-1:CAUSE_W] == '0)
      else $error("upper read bits nonzero"); // R10
  end

endmodule

// File: rtl/rcl_regfile.sv
module rcl_regfile
  import rcl_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int N_PERIPH = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [CAUSE_W-1:0]  cause_evt_i,
  output logic [N_PERIPH-1:0] periph_rst_no
);

  logic                cause_wr;
  logic [CAUSE_W-1:0]  cause_q;
  logic [N_PERIPH-1:0] lock_wr;
  logic [N_PERIPH-1:0] ctrl_wr;
  logic [N_PERIPH-1:0] lock_open;
  logic [N_PERIPH-1:0] ctrl_bits;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:CAUSE_W];
  assign cause_wr     = reg_we_i && (reg_addr_i == '0);

  rcl_cause_reg u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_en_i   (cause_wr),
    .clr_bits_i (reg_wdata_i[CAUSE_W-1:0]),
    .evt_i      (cause_evt_i),
    .cause_o    (cause_q)
  );

  for (genvar g = 0; g < N_PERIPH; g++) begin : g_periph
    assign lock_wr[g] = reg_we_i && (reg_addr_i == ADDR_W'(lock_addr(g)));
    assign ctrl_wr[g] = reg_we_i && (reg_addr_i == ADDR_W'(ctrl_addr(g, N_PERIPH)));

    rcl_lock_ctrl u_lock (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lock_wr_i   (lock_wr[g]),
      .ctrl_wr_i   (ctrl_wr[g]),
      .wbit_i      (reg_wdata_i[0]),
      .lock_open_o (lock_open[g]),
      .ctrl_o      (ctrl_bits[g])
    );

    assign periph_rst_no[g] = rst_ni & ctrl_bits[g];
  end

  rcl_read_mux #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .N_PERIPH (N_PERIPH)
  ) u_rmux (
    .addr_i  (reg_addr_i),
    .cause_i (cause_q),
    .lock_i  (lock_open),
    .ctrl_i  (ctrl_bits),
    .rdata_o (reg_rdata_o)
  );

  AST_RST_OUT_FOLLOWS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((periph_rst_no & ~ctrl_bits) == '0))
    else $error("peripheral released while control low"); // R8

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cause_wr, lock_wr, ctrl_wr}) <= 1)
    else $error("write decoded to several registers"); // R9

endmodule

// File: tb/tb_rcl_regfile.sv
module tb_rcl_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NP = 2;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [CW-1:0] evt = '0;
  logic [NP-1:0] prst_n;

  int n_checks = 0;
  int n_errors = 0;

  logic [CW-1:0] m_cause;
  logic [NP-1:0] m_lock;
  logic [NP-1:0] m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcl_regfile dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .reg_addr_i    (addr),
    .reg_we_i      (we),
    .reg_wdata_i   (wdata),
    .reg_rdata_o   (rdata),
    .cause_evt_i   (evt),
    .periph_rst_no (prst_n)
  );

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    case (a)
      8'h00: return {{(DW-CW){1'b0}}, m_cause};
      8'h04: return {{(DW-1){1'b0}}, m_lock[0]};
      8'h08: return {{(DW-1){1'b0}}, m_lock[1]};
      8'h0C: return {{(DW-1){1'b0}}, m_ctrl[0]};
      8'h10: return {{(DW-1){1'b0}}, m_ctrl[1]};
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [AW-1:0] a);
    case (a)
      8'h00: return "R4";
      8'h04, 8'h08: return "R6";
      8'h0C, 8'h10: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // One write with optional event pulse; model advances at the same edge.
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [CW-1:0] e);
    logic [CW-1:0] clr;
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; evt = e;
    @(posedge clk);
    clr = (a == 8'h00) ? d[CW-1:0] : '0;
    m_cause = (m_cause & ~clr) | e;
    if (a == 8'h04 && d[0]) m_lock[0] = 1'b0;
    if (a == 8'h08 && d[0]) m_lock[1] = 1'b0;
    if (a == 8'h0C && m_lock[0]) m_ctrl[0] = d[0];
    if (a == 8'h10 && m_lock[1]) m_ctrl[1] = d[0];
    @(negedge clk);
    we = 1'b0; evt = '0; wdata = '0;
  endtask

  task automatic pulse_evt(input logic [CW-1:0] e);
    @(negedge clk);
    evt = e;
    @(posedge clk);
    m_cause = m_cause | e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a);
    addr = a;
    #1;
    check(req, rdata, model_read(a));
  endtask

  task automatic check_all(input string tag);
    rd_check(tag == "" ? "R4" : tag, 8'h00);
    rd_check(tag == "" ? "R6" : tag, 8'h04);
    rd_check(tag == "" ? "R6" : tag, 8'h08);
    rd_check(tag == "" ? "R7" : tag, 8'h0C);
    rd_check(tag == "" ? "R7" : tag, 8'h10);
    check("R8", {{(DW-NP){1'b0}}, prst_n}, {{(DW-NP){1'b0}}, m_ctrl});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin : main
    logic [AW-1:0] ra;
    logic [DW-1:0] rd;
    logic [CW-1:0] re;
    void'($urandom(32'h5EED_1234));
    m_cause = 5'h01; m_lock = '1; m_ctrl = '1;

    repeat (3) @(negedge clk);
    check("R8", {{(DW-NP){1'b0}}, prst_n}, '0);   // outputs low while reset held
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1");

    // R2 each event bit lands in its own position
    wr(8'h00, 32'h1F, '0);
    for (int k = 0; k < CW; k++) begin
      pulse_evt(CW'(1) << k);
      rd_check("R2", 8'h00);
      wr(8'h00, 32'h1F, '0);
      rd_check("R4", 8'h00);
    end

    // R3 accumulation: watchdog then escalation then low-power exit
    pulse_evt(5'h04);
    pulse_evt(5'h08);
    pulse_evt(5'h02);
    rd_check("R3", 8'h00);
    check("R3", rdata, 32'h0000_000E);

    // R4 write zero keeps, write one clears only that bit
    wr(8'h00, 32'h0, '0);
    rd_check("R4", 8'h00);
    wr(8'h00, 32'h08, '0);
    rd_check("R4", 8'h00);
    check("R4", rdata, 32'h0000_0006);

    // R5 event and clear of same bit in same cycle: event wins, others still clear
    wr(8'h00, 32'h06, 5'h04);
    rd_check("R5", 8'h00);
    check("R5", rdata, 32'h0000_0004);

    // R10 upper bits written high stay zero and do not clear anything
    wr(8'h00, 32'hFFFF_FFE0, '0);
    rd_check("R10", 8'h00);
    wr(8'h0C, 32'hFFFF_FFFE, '0);
    rd_check("R10", 8'h0C);
    check("R8", {{(DW-NP){1'b0}}, prst_n}, {{(DW-NP){1'b0}}, m_ctrl});
    wr(8'h0C, 32'h1, '0);

    // R9 unmapped addresses read zero and writes there change nothing
    wr(8'h14, 32'hFFFF_FFFF, '0);
    wr(8'h02, 32'hFFFF_FFFF, '0);
    rd_check("R9", 8'h14);
    rd_check("R9", 8'h02);
    rd_check("R9", 8'hFC);
    check_all("R9");

    // R7/R8 control works while unlocked
    wr(8'h10, 32'h0, '0);
    check("R8", {{(DW-NP){1'b0}}, prst_n}, 32'h1);
    rd_check("R7", 8'h10);

    // R6 writing zero to lock leaves it open; writing one closes it
    wr(8'h08, 32'h0, '0);
    rd_check("R6", 8'h08);
    wr(8'h08, 32'h1, '0);
    rd_check("R6", 8'h08);
    check("R6", rdata, 32'h0);
    wr(8'h08, 32'h1, '0);
    wr(8'h08, 32'h0, '0);
    rd_check("R6", 8'h08);

    // R7 control frozen while locked (held at 0)
    wr(8'h10, 32'h1, '0);
    rd_check("R7", 8'h10);
    check("R7", rdata, 32'h0);
    check("R8", {{(DW-NP){1'b0}}, prst_n}, 32'h1);
    check_all("");

    // random mix
    for (int n = 0; n < 600; n++) begin
      case ($urandom % 8)
        0: ra = 8'h00;
        1: ra = 8'h04;
        2: ra = 8'h08;
        3, 4: ra = 8'h0C;
        5: ra = 8'h10;
        6: ra = 8'h10 + 8'(($urandom % 60) + 1);
        default: ra = 8'(($urandom % 4) * 4);
      endcase
      rd = $urandom;
      if (ra == 8'h04 || ra == 8'h08) rd[0] = (($urandom % 16) == 0);
      re = (($urandom % 4) == 0) ? CW'($urandom) : '0;
      wr(ra, rd, re);
      check_all("");
      rd_check(req_of(ra), ra);
    end

    // R1 reset again restores everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", {{(DW-NP){1'b0}}, prst_n}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    m_cause = 5'h01; m_lock = '1; m_ctrl = '1;
    @(negedge clk);
    check_all("R1");

    finish_run();
  end

endmodule